// File: doc/BRIEF.md
# Digital Timing Recovery Loop

This block is the feedback loop that keeps a resampled symbol stream aligned to the symbol centres. For every incoming sample it forms a timing error by comparing the sample against the decided symbol. A proportional-integral filter smooths that error. The filter output then moves a 16-bit phase accumulator, whose value is the fractional sampling phase for the interpolator downstream. When the accumulator crosses a symbol boundary, the interpolator is told to consume one extra input sample (skip) or to reuse one (stuff).

A start strobe resets the loop into a fast acquisition mode with high gains. After a programmed number of symbols, the loop drops into a tracking mode whose gains are lower, so that it follows slow rate drift without reacting to noise. A lock flag reports when the filtered error has stayed small for a sustained run of symbols.

Top module: `timing_recovery_loop`

## Requirements
- R1: After reset, `fracPhase` is 0, `advance` is 1, and `locked` and `tracking` are 0. Symbols presented before the first `start` change none of these.
- R2: The timing error for symbol n is e = y[n]·d[n-1] − y[n-1]·d[n]. The decision codes are 2'b01 = +1 and 2'b11 = −1, and both 2'b00 and 2'b10 mean 0. When every sample equals its decision times a constant, the error is zero and the phase does not move.
- R3: Per symbol, the integrator adds e>>>KI (arithmetic shift) and saturates at ±16383. The filter output is ctrl = (e>>>KP) + updated integrator.
- R4: The accumulator takes phase+ctrl modulo 2^16. `advance` is 2 (skip) when that sum reaches 2^16 or more, 0 (stuff) when the sum is below zero, and 1 otherwise. Both `advance` and `fracPhase` update on the clock edge that accepts the symbol.
- R5: After `start` the loop uses the acquisition shifts KP=2 and KI=6. Once `acqSymbols` symbols have been processed, `tracking` rises and the shifts become KP=4 and KI=9. If `acqSymbols` is 0, tracking begins right at `start`. Tracking stays set until the next `start`.
- R6: `start` clears the integrator, the previous sample and decision, the phase (to 0), `advance` (to 1) and the lock state. A symbol presented in the same cycle as `start` is discarded.
- R7: `locked` rises after 64 consecutive symbols with |ctrl| < `lockThresh`. It falls on the first symbol that fails that test.
- R8: In a cycle with `symValid` low and no `start`, no output and no loop state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Restart the loop in acquisition mode |
| symValid | input | 1 | A sample and its decision are present |
| sampleIn | input | 12 | Signed interpolated sample |
| decision | input | 2 | Ternary decision code |
| acqSymbols | input | 16 | Number of symbols in acquisition mode |
| lockThresh | input | 16 | Lock threshold on the filter-output magnitude |
| fracPhase | output | 16 | Fractional sampling phase |
| advance | output | 2 | Input samples to consume: 0 stuff, 1 normal, 2 skip |
| locked | output | 1 | Loop lock indication |
| tracking | output | 1 | Loop is in the low-gain tracking mode |

## Verification
A reference model in the bench runs in lockstep with the design, and the bench goes after the edges of the loop. These are the switch from acquisition to tracking at exactly the programmed symbol count, with a count of zero as a case of its own; positive and negative accumulator wraps; and integrator saturation, which shows up as a fixed phase step once the loop is pinned. A design that moved to tracking one symbol late, or flagged a wrap in the wrong direction, would drift away from the model's phase. One that let the integrator wrap instead of clipping would make a large negative phase step where the bench expects +16383. Further directed tests cover the lock edge (still clear after 63 quiet symbols, set after 64, cleared by one large error), a `start` that arrives together with a symbol, and idle cycles during which the inputs change freely.

// File: rtl/trl_pkg.sv
package trl_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic clear;   // restart: zero history, integrator, phase
    logic step;    // process the current symbol
    logic track;   // use tracking gains
  } loop_ctrl_t;

  // Ternary decision decode: 01 -> +1, 11 -> -1, else 0
  function automatic logic signed [1:0] decodeSym(input logic [1:0] code);
    case (code)
      2'b01:   return 2'sb01;
      2'b11:   return 2'sb11;
      default: return 2'sb00;
    endcase
  endfunction

endpackage

// File: rtl/trl_datapath.sv
module trl_datapath
  import trl_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 16,
  parameter int KP_ACQ   = 2,
  parameter int KI_ACQ   = 6,
  parameter int KP_TRK   = 4,
  parameter int KI_TRK   = 9
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  loop_ctrl_t                 ctrl,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic [1:0]                 decision,
  output logic [ACC_W-1:0]           fracPhase,
  output logic [1:0]                 advance,
  output logic [ACC_W:0]             filtMag
);

  localparam int ERR_W  = SAMPLE_W + 2;
  localparam int CTRL_W = ACC_W + 1;
  localparam int SUM_W  = ACC_W + 2;
  localparam int SH_W   = 5;
  localparam logic signed [CTRL_W-1:0] LIM_POS = CTRL_W'((2 ** (ACC_W - 2)) - 1);
  localparam logic signed [CTRL_W-1:0] LIM_NEG = -LIM_POS;

  logic signed [SAMPLE_W-1:0] yPrev;
  logic signed [1:0]          dPrev;
  logic signed [ACC_W-1:0]    integ;
  logic [ACC_W-1:0]           phase;
  logic [1:0]                 adv;

  logic signed [1:0]        dCur;
  logic signed [ERR_W-1:0]  errCur;
  logic signed [CTRL_W-1:0] errExt, propTerm, integStep, integSum, integNext, ctrlOut;
  logic signed [SUM_W-1:0]  phaseSum;
  logic [SH_W-1:0]          kpSh, kiSh;

  function automatic logic signed [ERR_W-1:0] scaleByDec(
    input logic signed [SAMPLE_W-1:0] y, input logic signed [1:0] d);
    logic signed [ERR_W-1:0] yExt;
    yExt = ERR_W'(y);
    case (d)
      2'sb01:  return yExt;
      2'sb11:  return -yExt;
      default: return '0;
    endcase
  endfunction

  // Mueller-Muller style detector
  always_comb begin
    dCur   = decodeSym(decision);
    errCur = scaleByDec(sampleIn, dPrev) - scaleByDec(yPrev, dCur);
    errExt = CTRL_W'(errCur);
  end

  // Gain selection by mode
  always_comb begin
    kpSh = ctrl.track ? SH_W'(KP_TRK) : SH_W'(KP_ACQ);
    kiSh = ctrl.track ? SH_W'(KI_TRK) : SH_W'(KI_ACQ);
  end

  // Proportional-integral filter with saturating integrator
  always_comb begin
    propTerm  = errExt >>> kpSh;
    integStep = errExt >>> kiSh;
    integSum  = CTRL_W'(integ) + integStep;
    if (integSum > LIM_POS)      integNext = LIM_POS;
    else if (integSum < LIM_NEG) integNext = LIM_NEG;
    else                         integNext = integSum;
    ctrlOut = propTerm + integNext;
    filtMag = ctrlOut[CTRL_W-1] ? unsigned'(-ctrlOut) : unsigned'(ctrlOut);
  end

  // Phase accumulator with wrap detection
  always_comb begin
    phaseSum = $signed({2'b00, phase}) + SUM_W'(ctrlOut);
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear) begin
      yPrev <= '0;
      dPrev <= '0;
      integ <= '0;
      phase <= '0;
      adv   <= 2'd1;
    end else if (ctrl.step) begin
      yPrev <= sampleIn;
      dPrev <= dCur;
      integ <= ACC_W'(integNext);
      phase <= phaseSum[ACC_W-1:0];
      if (phaseSum[SUM_W-1])   adv <= 2'd0;
      else if (phaseSum[ACC_W]) adv <= 2'd2;
      else                     adv <= 2'd1;
    end
  end

  assign fracPhase = phase;
  assign advance   = adv;

endmodule

// File: rtl/trl_control.sv
module trl_control
  import trl_pkg::*;
#(
  parameter int ACC_W    = 16,
  parameter int ACQ_W    = 16,
  parameter int LOCK_LEN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             symValid,
  input  logic [ACQ_W-1:0] acqSymbols,
  input  logic [ACC_W-1:0] lockThresh,
  input  logic [ACC_W:0]   filtMag,
  output loop_ctrl_t       ctrl,
  output logic             locked,
  output logic             tracking
);

  localparam int LCNT_W = $clog2(LOCK_LEN + 1);
  localparam logic [LCNT_W-1:0] LOCK_MAX = LCNT_W'(LOCK_LEN);

  logic              running;
  logic              trackQ;
  logic [ACQ_W-1:0]  acqCnt;
  logic [LCNT_W-1:0] lockCnt;
  logic              stepNow;
  logic [ACQ_W:0]    acqNext;

  assign stepNow = running && symValid && !start;
  assign acqNext = {1'b0, acqCnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      trackQ  <= 1'b0;
      acqCnt  <= '0;
      lockCnt <= '0;
    end else if (start) begin
      running <= 1'b1;
      trackQ  <= (acqSymbols == '0);
      acqCnt  <= '0;
      lockCnt <= '0;
    end else if (stepNow) begin
      if (!trackQ) begin
        acqCnt <= acqNext[ACQ_W-1:0];
        if (acqNext >= {1'b0, acqSymbols}) trackQ <= 1'b1;
      end
      if (filtMag < {1'b0, lockThresh}) begin
        if (lockCnt != LOCK_MAX) lockCnt <= lockCnt + 1'b1;
      end else begin
        lockCnt <= '0;
      end
    end
  end

  always_comb begin
    ctrl.clear = start;
    ctrl.step  = stepNow;
    ctrl.track = trackQ;
  end

  assign locked   = (lockCnt == LOCK_MAX);
  assign tracking = trackQ;

endmodule

// File: rtl/timing_recovery_loop.sv
module timing_recovery_loop
  import trl_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 16,
  parameter int ACQ_W    = 16,
  parameter int LOCK_LEN = 64,
  parameter int KP_ACQ   = 2,
  parameter int KI_ACQ   = 6,
  parameter int KP_TRK   = 4,
  parameter int KI_TRK   = 9
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic                       symValid,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic [1:0]                 decision,
  input  logic [ACQ_W-1:0]           acqSymbols,
  input  logic [ACC_W-1:0]           lockThresh,
  output logic [ACC_W-1:0]           fracPhase,
  output logic [1:0]                 advance,
  output logic                       locked,
  output logic                       tracking
);

  loop_ctrl_t     loopCtrl;
  logic [ACC_W:0] filtMag;

  trl_control #(
    .ACC_W(ACC_W), .ACQ_W(ACQ_W), .LOCK_LEN(LOCK_LEN)
  ) i_control (
    .clk(clk), .rstN(rstN), .start(start), .symValid(symValid),
    .acqSymbols(acqSymbols), .lockThresh(lockThresh), .filtMag(filtMag),
    .ctrl(loopCtrl), .locked(locked), .tracking(tracking)
  );

  trl_datapath #(
    .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W),
    .KP_ACQ(KP_ACQ), .KI_ACQ(KI_ACQ), .KP_TRK(KP_TRK), .KI_TRK(KI_TRK)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .ctrl(loopCtrl), .sampleIn(sampleIn),
    .decision(decision), .fracPhase(fracPhase), .advance(advance),
    .filtMag(filtMag)
  );

endmodule

// File: rtl/trl_checker.sv
module trl_checker #(
  parameter int ACC_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             symValid,
  input logic [ACC_W-1:0] fracPhase,
  input logic [1:0]       advance,
  input logic             locked,
  input logic             tracking
);

  assert_adv_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    advance != 2'd3);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!symValid && !start) |=> ($stable(fracPhase) && $stable(advance)
                              && $stable(locked) && $stable(tracking)));

  assert_start_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (fracPhase == '0 && advance == 2'd1 && !locked));

  assert_track_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (tracking && !start) |=> tracking);

  assert_lock_needs_symbol_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && !symValid) |=> !locked);

endmodule

bind timing_recovery_loop trl_checker #(.ACC_W(ACC_W)) i_trl_checker (.*);

// File: tb/test_timing_recovery_loop.sv
module test_timing_recovery_loop;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        symValid = 1'b0;
  logic signed [11:0] sampleIn = '0;
  logic [1:0]  decision = 2'b00;
  logic [15:0] acqSymbols = '0;
  logic [15:0] lockThresh = '0;
  logic [15:0] fracPhase;
  logic [1:0]  advance;
  logic        locked;
  logic        tracking;

  always #10 clk = ~clk;  // 50 MHz

  timing_recovery_loop i_timing_recovery_loop (
    .clk(clk), .rstN(rstN), .start(start), .symValid(symValid),
    .sampleIn(sampleIn), .decision(decision), .acqSymbols(acqSymbols),
    .lockThresh(lockThresh), .fracPhase(fracPhase), .advance(advance),
    .locked(locked), .tracking(tracking)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int mPhase, mInteg, mYPrev, mDPrev, mAcqCnt, mAcqLen, mThr, mLockCnt, mAdv;
  bit mTrack;

  // stimulus table: sample, decision code
  localparam int NVEC = 16;
  localparam int VEC_Y [NVEC] = '{ 400, -380, 20, 1500, -900, 300, -2047, 2047,
                                   60, -10, 700, -700, 1200, 5, -1600, 250 };
  localparam logic [1:0] VEC_D [NVEC] = '{ 2'b01, 2'b11, 2'b00, 2'b01, 2'b11, 2'b10, 2'b11, 2'b01,
                                           2'b00, 2'b11, 2'b01, 2'b11, 2'b01, 2'b10, 2'b11, 2'b01 };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int decVal(input logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b11) return -1;
    return 0;
  endfunction

  task automatic modelStart(input int acq, input int thr);
    mPhase = 0; mInteg = 0; mYPrev = 0; mDPrev = 0; mAcqCnt = 0;
    mAcqLen = acq; mThr = thr; mLockCnt = 0; mAdv = 1; mTrack = (acq == 0);
  endtask

  task automatic modelStep(input int y, input logic [1:0] code);
    int d, e, kp, ki, prop, ctl, sum, mag;
    d  = decVal(code);
    e  = y * mDPrev - mYPrev * d;
    kp = mTrack ? 4 : 2;
    ki = mTrack ? 9 : 6;
    prop = e >>> kp;
    mInteg = mInteg + (e >>> ki);
    if (mInteg > 16383) mInteg = 16383;
    if (mInteg < -16383) mInteg = -16383;
    ctl = prop + mInteg;
    sum = mPhase + ctl;
    if (sum < 0) mAdv = 0; else if (sum >= 65536) mAdv = 2; else mAdv = 1;
    mPhase = (sum + 65536) % 65536;
    mYPrev = y; mDPrev = d;
    if (!mTrack) begin
      mAcqCnt++;
      if (mAcqCnt >= mAcqLen) mTrack = 1;
    end
    mag = (ctl < 0) ? -ctl : ctl;
    if (mag < mThr) begin if (mLockCnt < 64) mLockCnt++; end
    else mLockCnt = 0;
  endtask

  task automatic doStart(input int acq, input int thr);
    @(negedge clk);
    start = 1'b1; acqSymbols = 16'(acq); lockThresh = 16'(thr);
    @(negedge clk);
    start = 1'b0;
    modelStart(acq, thr);
  endtask

  // one symbol, then compare all outputs against the model
  task automatic sendSym(input int y, input logic [1:0] d, input string req);
    @(negedge clk);
    sampleIn = 12'(y); decision = d; symValid = 1'b1;
    @(negedge clk);
    symValid = 1'b0;
    modelStep(y, d);
    chk({req, " phase"}, int'(fracPhase), mPhase);
    chk({req, " advance"}, int'(advance), mAdv);
    chk({req, " tracking"}, int'(tracking), int'(mTrack));
    chk({req, " locked"}, int'(locked), (mLockCnt >= 64) ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int skips, stuffs, prevPh, delta;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset phase", int'(fracPhase), 0);
    chk("R1 reset advance", int'(advance), 1);
    chk("R1 reset locked", int'(locked), 0);
    chk("R1 reset tracking", int'(tracking), 0);
    // R1: symbol before first start ignored
    @(negedge clk); sampleIn = 12'sd1800; decision = 2'b01; symValid = 1'b1;
    @(negedge clk); symValid = 1'b0; sampleIn = 12'sd0;
    @(negedge clk); sampleIn = 12'sd1800; decision = 2'b00; symValid = 1'b1;
    @(negedge clk); symValid = 1'b0;
    chk("R1 idle phase", int'(fracPhase), 0);
    chk("R1 idle advance", int'(advance), 1);

    // R2 R3 R4 R5: table walk, switch to tracking after 8 symbols
    doStart(8, 50);
    chk("R5 acquisition after start", int'(tracking), 0);
    for (int i = 0; i < NVEC; i++) sendSym(VEC_Y[i], VEC_D[i], "R2/R5 table");

    // R8: idle cycles with changing inputs
    prevPh = int'(fracPhase);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); sampleIn = 12'(i * 300 - 700); decision = 2'(i);
    end
    @(negedge clk);
    chk("R8 idle phase", int'(fracPhase), prevPh);
    chk("R8 idle advance", int'(advance), mAdv);

    // R2: zero error keeps phase still
    doStart(3, 10);
    for (int i = 0; i < 6; i++) sendSym((i % 2 == 0) ? 700 : -700, (i % 2 == 0) ? 2'b01 : 2'b11, "R2 zero err");
    chk("R2 zero error phase", int'(fracPhase), 0);

    // R4 / R3: positive drive, wraps then saturation
    doStart(5000, 1);
    skips = 0;
    for (int t = 0; t < 600; t++) begin
      sendSym(1000, 2'b01, "R4 pos");
      if (advance == 2'd2) skips++;
      sendSym(2000, 2'b00, "R4 pos");
      if (advance == 2'd2) skips++;
      prevPh = int'(fracPhase);
      sendSym(0, 2'b00, "R3 pos");
      if (advance == 2'd2) skips++;
    end
    chk("R4 skip seen", int'(skips > 0), 1);
    delta = (int'(fracPhase) - prevPh + 65536) % 65536;
    chk("R3 saturated step", delta, 16383);

    // R4: negative drive produces stuffs
    doStart(5000, 1);
    stuffs = 0;
    for (int t = 0; t < 60; t++) begin
      sendSym(1000, 2'b01, "R4 neg");
      if (advance == 2'd0) stuffs++;
      sendSym(-2000, 2'b00, "R4 neg");
      if (advance == 2'd0) stuffs++;
      sendSym(0, 2'b00, "R4 neg");
      if (advance == 2'd0) stuffs++;
    end
    chk("R4 stuff seen", int'(stuffs > 0), 1);

    // R5: zero acquisition length
    doStart(0, 10);
    chk("R5 immediate tracking", int'(tracking), 1);
    sendSym(900, 2'b01, "R5 trk gains");
    sendSym(900, 2'b00, "R5 trk gains");

    // R7: lock after 64 quiet symbols, drop on large error
    doStart(4, 10);
    for (int i = 0; i < 63; i++) sendSym(500, 2'b01, "R7 quiet");
    chk("R7 not locked at 63", int'(locked), 0);
    sendSym(500, 2'b01, "R7 quiet");
    chk("R7 locked at 64", int'(locked), 1);
    sendSym(2000, 2'b00, "R7 drop");
    chk("R7 unlocked", int'(locked), 0);

    // R6: start together with a symbol
    sendSym(1500, 2'b01, "R6 pre");
    @(negedge clk);
    start = 1'b1; symValid = 1'b1; sampleIn = 12'sd2000; decision = 2'b11; acqSymbols = 16'd2;
    @(negedge clk);
    start = 1'b0; symValid = 1'b0;
    modelStart(2, 10);
    chk("R6 phase cleared", int'(fracPhase), 0);
    chk("R6 advance cleared", int'(advance), 1);
    chk("R6 lock cleared", int'(locked), 0);
    // history cleared: first error is zero regardless of previous symbol
    sendSym(1900, 2'b11, "R6 history");
    chk("R6 first phase", int'(fracPhase), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule